// File: doc/BRIEF.md
# Sticky-Enable Non-Maskable Interrupt Input

This block sits between an external interrupt pin and the interrupt controller. Out of reset the pin is nothing more than an ordinary input bit: software can read its level, and no transition on it has any effect. Software arms the non-maskable function by writing a control byte with the arm bit set. From then on the function stays armed until the next reset. Software has no way to turn it off.

The raw pin first passes through a two-stage synchronizer. It then goes through a digital deglitch filter whose hold length N (0 to 255 clocks) comes from an input. The filtered level moves to a new value only after the synchronized level has disagreed with it for N+1 consecutive clocks. An accepted high-to-low change of the filtered level, seen while the function is armed, sets a pending request. The request stays set until the interrupt controller pulses the acknowledge input.

The interface is control and status only. There is no data stream, so no valid/ready handshake and no back-pressure. Every pin is a plain level sampled on the rising clock edge.

Top module: `nmi_sticky_gate`

## Requirements
- R1: While reset is asserted and immediately after it, `nmi_en_o` and `nmi_req_o` are 0 and the filtered level is high.
- R2: A cycle with `ctrl_wr_i`=1 and `ctrl_wdata_i` bit 4 = 1 arms the function: `nmi_en_o` is 1 from the next clock. A write with bit 4 = 0 does not arm it, whatever the other bits hold.
- R3: Once armed, `nmi_en_o` stays 1 through any later write, including writes with bit 4 = 0. Only reset returns it to 0.
- R4: `port_rd_o` bit 5 equals the level `pin_i` had two clock edges earlier, whether or not the function is armed. All other bits of `port_rd_o` read 0.
- R5: A change of the synchronized pin level reaches the filtered level only after it has persisted for N+1 consecutive clocks, where N = `filt_len_i`. A shorter excursion is discarded and raises nothing. N = 0 means no filtering.
- R6: While armed, an accepted falling edge sets `nmi_req_o`. It rises right after the (N+3)th rising clock edge that samples `pin_i` low. A rising edge never raises a request.
- R7: A falling edge accepted while the function is disarmed leaves no pending request, even after the function is armed later.
- R8: `nmi_req_o` holds until `nmi_ack_i` is sampled high. With no new falling edge in that cycle, it reads 0 from the next clock.
- R9: If an accepted falling edge lands in the same cycle as the acknowledge, `nmi_req_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin, idle high |
| filt_len_i | input | 8 | Deglitch hold length N |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data; bit 4 arms the function |
| port_rd_o | output | 8 | Port data read value; bit 5 is the synchronized pin level |
| nmi_en_o | output | 1 | Function armed |
| nmi_req_o | output | 1 | Pending non-maskable request |
| nmi_ack_i | input | 1 | Acknowledge pulse from the interrupt controller |

## Verification
A lost or cleared arm flag shows up as `nmi_en_o` dropping on a following clock. It also shows up as a missing request after a long low pulse. A miscounting filter moves the request edge by whole cycles, or lets a pulse of exactly N clocks through. The bench therefore probes the widths N and N+1, and it samples the request on the exact (N+3)th edge and on the edge before it. A request latch that favours the acknowledge over a new edge loses the request in the single overlapping cycle. A latch that remembers disarmed edges shows a request immediately after arming.

// File: rtl/nmi_cfg_pkg.sv
package nmi_cfg_pkg;
  localparam int CTRL_W  = 8;
  localparam int ARM_BIT = 4;
  localparam int PORT_W  = 8;
  localparam int LVL_BIT = 5;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } pin_lvl_e;
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_deglitch.sv
module nmi_deglitch
  import nmi_cfg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             lvl_o,
  output logic             fall_o
);
  pin_lvl_e         stable_q;
  logic [CNT_W-1:0] run_q;
  logic             differ;
  logic             accept;

  always_comb begin
    differ = (lvl_i != stable_q);
    accept = differ && (run_q >= len_i);
    fall_o = accept && (lvl_i == LVL_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= LVL_HIGH;
      run_q    <= '0;
    end else if (!differ) begin
      run_q    <= '0;
    end else if (accept) begin
      stable_q <= pin_lvl_e'(lvl_i);
      run_q    <= '0;
    end else begin
      run_q    <= run_q + 1'b1;
    end
  end

  assign lvl_o = stable_q;
endmodule

// File: rtl/nmi_arm_latch.sv
module nmi_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic arm_o
);
  logic arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     arm_q <= 1'b0;
    else if (set_i) arm_q <= 1'b1;
  end

  assign arm_o = arm_q;
endmodule

// File: rtl/nmi_pend.sv
module nmi_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic fall_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;
  logic req_d;

  always_comb begin
    req_d = req_q;
    if (ack_i)          req_d = 1'b0;
    if (fall_i && arm_i) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/nmi_sticky_gate.sv
module nmi_sticky_gate
  import nmi_cfg_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [LEN_W-1:0]  filt_len_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [PORT_W-1:0] port_rd_o,
  output logic              nmi_en_o,
  output logic              nmi_req_o,
  input  logic              nmi_ack_i
);
  logic sync_lvl;
  logic filt_lvl;
  logic filt_fall;
  logic arm;
  logic arm_set;
  logic unused_bits;

  nmi_pin_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (sync_lvl)
  );

  nmi_deglitch #(
    .CNT_W(LEN_W)
  ) filt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (sync_lvl),
    .len_i (filt_len_i),
    .lvl_o (filt_lvl),
    .fall_o(filt_fall)
  );

  assign arm_set = ctrl_wr_i && ctrl_wdata_i[ARM_BIT];

  nmi_arm_latch arm_i (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(arm_set),
    .arm_o(arm)
  );

  nmi_pend pend_i (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (arm),
    .fall_i(filt_fall),
    .ack_i (nmi_ack_i),
    .req_o (nmi_req_o)
  );

  always_comb begin
    port_rd_o          = '0;
    port_rd_o[LVL_BIT] = sync_lvl;
  end

  assign nmi_en_o    = arm;
  assign unused_bits = ^{filt_lvl, ctrl_wdata_i};
endmodule

// File: rtl/nmi_sticky_gate_chk.sv
module nmi_sticky_gate_chk
  import nmi_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pin_i,
  input logic              ctrl_wr_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [PORT_W-1:0] port_rd_o,
  input logic              nmi_en_o,
  input logic              nmi_req_o,
  input logic              nmi_ack_i
);
  logic [1:0] age_q;
  logic [PORT_W-1:0] other_mask;
  logic unused_chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  always_comb begin
    other_mask          = '1;
    other_mask[LVL_BIT] = 1'b0;
  end

  assign unused_chk = ^ctrl_wdata_i;

  assert_arm_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i[ARM_BIT]) |=> nmi_en_o);

  assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_en_o |=> nmi_en_o);

  assert_level_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (port_rd_o[LVL_BIT] == $past(pin_i, 2)));

  assert_other_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd_o & other_mask) == '0);

  assert_no_req_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en_o |-> !nmi_req_o);

  assert_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req_o && !nmi_ack_i) |=> nmi_req_o);
endmodule

bind nmi_sticky_gate nmi_sticky_gate_chk chk_i (.*);

// File: tb/nmi_sticky_gate_tb_top.sv
module nmi_sticky_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic [7:0] flen = 8'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] prd;
  logic       en;
  logic       req;
  logic       ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nmi_sticky_gate dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .filt_len_i  (flen),
    .ctrl_wr_i   (wr),
    .ctrl_wdata_i(wdata),
    .port_rd_o   (prd),
    .nmi_en_o    (en),
    .nmi_req_o   (req),
    .nmi_ack_i   (ack)
  );

  // {filter length N, low pulse width in clocks}
  localparam logic [15:0] VEC [9] = '{
    {8'd0,  8'd1},  {8'd1,  8'd1},  {8'd1,  8'd2},
    {8'd3,  8'd3},  {8'd3,  8'd4},  {8'd5,  8'd2},
    {8'd10, 8'd10}, {8'd10, 8'd11}, {8'd20, 8'd25}
  };

  task automatic check(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = 8'd0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 en in reset", {7'd0, en}, 8'd0);
    check("R1 req in reset", {7'd0, req}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 en after reset", {7'd0, en}, 8'd0);
    check("R4 port idle high", prd, 8'h20);

    // R7: fall while disarmed, then arm
    flen = 8'd2;
    pin = 1'b0;
    repeat (8) @(negedge clk);
    check("R4 port low disarmed", prd, 8'h00);
    check("R7 no req disarmed", {7'd0, req}, 8'd0);
    do_write(8'hEF);
    check("R2 other bits do not arm", {7'd0, en}, 8'd0);
    do_write(8'h10);
    check("R2 arm bit sets en", {7'd0, en}, 8'd1);
    repeat (3) @(negedge clk);
    check("R7 no stale req after arm", {7'd0, req}, 8'd0);
    pin = 1'b1;
    repeat (8) @(negedge clk);
    check("R6 rising edge no req", {7'd0, req}, 8'd0);
    do_write(8'h00);
    check("R3 write zero keeps en", {7'd0, en}, 8'd1);

    // vector table: R5 filter width, R6 request, R8 ack
    foreach (VEC[i]) begin
      logic [7:0] n;
      logic [7:0] w;
      logic       exp;
      n = VEC[i][15:8];
      w = VEC[i][7:0];
      exp = (int'(w) >= int'(n) + 1);
      @(negedge clk); flen = n; pin = 1'b0;
      repeat (int'(w)) @(negedge clk);
      pin = 1'b1;
      repeat (int'(n) + 8) @(negedge clk);
      check($sformatf("R5 R6 vec%0d N=%0d W=%0d", i, n, w), {7'd0, req}, {7'd0, exp});
      pulse_ack();
      check($sformatf("R8 ack clears vec%0d", i), {7'd0, req}, 8'd0);
    end

    // R6 exact latency with N=3
    flen = 8'd3;
    repeat (4) @(negedge clk);
    pin = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R6 req not before edge N+3", {7'd0, req}, 8'd0);
    @(negedge clk);
    check("R6 req at edge N+3", {7'd0, req}, 8'd1);
    check("R4 port low armed", prd, 8'h00);
    repeat (3) @(negedge clk);
    check("R8 req held without ack", {7'd0, req}, 8'd1);

    // R9: new fall in the ack cycle
    pin = 1'b1;
    repeat (10) @(negedge clk);
    pin = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R9 fall during ack keeps req", {7'd0, req}, 8'd1);
    pulse_ack();
    check("R8 ack alone clears", {7'd0, req}, 8'd0);
    pin = 1'b1;
    repeat (10) @(negedge clk);

    // R3: only reset disarms
    apply_reset();
    check("R3 reset clears en", {7'd0, en}, 8'd0);
    check("R1 req after reset", {7'd0, req}, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule